// File: doc/BRIEF.md
# Grouped Nibble Memory Access Engine

This block keeps a state memory for an operator console. The memory is split into groups, each group holds sixteen entries, and every entry stores a 4-bit code, so one entry can express sixteen distinct states. A remote engine carries out read, write and clear runs over consecutive entries. Each run is described by a request that has already been decoded into nibbles: an operation code, a group number made of two nibbles, a starting entry, and a run length made of two nibbles.

Write data enters and read data leaves one nibble per valid/ready handshake. A clear run needs no data and fills every entry it covers with the code F. A separate local port lets a panel scanner store button states and lets a lamp driver read entries back. When both sides want the memory in the same cycle, the local port wins.

Group 0 is kept for local interrupt bookkeeping, so the remote engine may read it but may never change it. Requests that are malformed or out of range are refused up front with an error pulse, and the memory is left untouched. A finished run is marked with a done pulse.

Top module: `gnm_engine`

## Requirements
- R1: Every entry is 4 bits wide and reset sets it to 0. A local read (loc_en=1, loc_we=0) shows the stored code on loc_rdata in the cycle after the request. A local write (loc_en=1, loc_we=1) stores loc_wdata.
- R2: A request is accepted on req_start while busy is low. The group is {req_grp_hi, req_grp_lo}, the run length is {req_cnt_hi, req_cnt_lo}, and the operation codes are 1 = read, 2 = write, 3 = clear.
- R3: A write run takes exactly one nibble per wr_valid/wr_ready handshake and stores the nibbles in consecutive entries. The entry index advances first and carries into the group number after entry F.
- R4: A read run presents the consecutive entries in order on rd_nib with rd_valid high, and moves on only when rd_ready is high.
- R5: A clear run sets every entry it covers to F, one entry per cycle.
- R6: A write or clear run that starts in group 0 is refused. A read run in group 0 is allowed.
- R7: A run length of 0, or of more than 16, is refused.
- R8: A run whose last entry would lie past entry F of the last group (group NGRP-1) is refused.
- R9: Any operation code other than 1, 2 or 3 is refused. Every refusal raises err for one cycle in the cycle after req_start, leaves busy low and does not change the memory.
- R10: In any cycle where loc_en is high, the remote side makes no handshake and writes nothing: wr_ready and rd_valid stay low, and the run resumes afterwards with no data lost.
- R11: busy goes high in the cycle after an accepted request. done goes high for exactly one cycle, in the cycle after the final transfer, and busy is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, taken while busy is low |
| req_op | input | 4 | Operation code (1 read, 2 write, 3 clear) |
| req_grp_hi | input | 4 | Group number, high nibble |
| req_grp_lo | input | 4 | Group number, low nibble |
| req_ent | input | 4 | Starting entry within the group |
| req_cnt_hi | input | 4 | Run length, high nibble |
| req_cnt_lo | input | 4 | Run length, low nibble |
| wr_valid | input | 1 | Write nibble available |
| wr_nib | input | 4 | Write nibble |
| wr_ready | output | 1 | Engine takes the write nibble this cycle |
| rd_valid | output | 1 | Read nibble available |
| rd_nib | output | 4 | Read nibble |
| rd_ready | input | 1 | Consumer takes the read nibble |
| loc_en | input | 1 | Local access request |
| loc_we | input | 1 | Local access is a write |
| loc_grp | input | 8 | Local group number |
| loc_ent | input | 4 | Local entry index |
| loc_wdata | input | 4 | Local write code |
| loc_rdata | output | 4 | Local read code, registered |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run has finished |
| err | output | 1 | One-cycle pulse when a request is refused |

## Verification
The bench builds the engine with NGRP set to 4, which gives a 64-entry memory. With only four groups, the top-of-memory limit sits at group 3, entry F. A sixteen-entry run that ends exactly on that boundary and one that overshoots it by a single entry can both be tried in a short run. The small depth also lets the bench read back the whole memory through the local port after every request. That read-back shows that refused requests changed nothing and that runs crossing from one group into the next carried the address correctly.

// File: rtl/gnm_pkg.sv
package gnm_pkg;

    localparam int ENT_W   = 4;
    localparam int ENT_N   = 16;
    localparam int GRP_W   = 8;
    localparam int CNT_W   = 8;
    localparam int MAX_RUN = 16;
    localparam logic [3:0] CLEAR_CODE = 4'hF;

    localparam logic [3:0] OP_READ  = 4'd1;
    localparam logic [3:0] OP_WRITE = 4'd2;
    localparam logic [3:0] OP_CLEAR = 4'd3;

    typedef enum logic {S_IDLE, S_RUN} seq_state_e;

    typedef struct packed {
        logic [3:0]       op;
        logic [GRP_W-1:0] grp;
        logic [ENT_W-1:0] ent;
        logic [CNT_W-1:0] cnt;
    } run_req_t;

    function automatic logic op_known(input logic [3:0] op);
        return (op == OP_READ) || (op == OP_WRITE) || (op == OP_CLEAR);
    endfunction

    function automatic logic op_modifies(input logic [3:0] op);
        return (op == OP_WRITE) || (op == OP_CLEAR);
    endfunction

endpackage

// File: rtl/gnm_req_check.sv
module gnm_req_check
    import gnm_pkg::*;
#(
    parameter int NGRP = 256
) (
    input  run_req_t req,
    output logic     ok
);
    localparam int LAST = NGRP * ENT_N - 1;

    logic [12:0] first_lin;
    logic [12:0] last_lin;
    logic        len_ok;
    logic        range_ok;
    logic        grp0_hit;

    always_comb begin
        first_lin = {1'b0, req.grp, req.ent};
        last_lin  = first_lin + {5'd0, req.cnt} - 13'd1;
        len_ok    = (req.cnt != '0) && (req.cnt <= CNT_W'(MAX_RUN));
        range_ok  = (int'(last_lin) <= LAST);
        grp0_hit  = (req.grp == '0) && op_modifies(req.op);
        ok        = op_known(req.op) && len_ok && range_ok && !grp0_hit;
    end

endmodule

// File: rtl/gnm_seq.sv
module gnm_seq
    import gnm_pkg::*;
#(
    parameter int NGRP = 256,
    localparam int AW  = $clog2(NGRP) + ENT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  run_req_t      req,
    input  logic          req_ok,
    input  logic          loc_busy,
    input  logic          wr_valid,
    input  logic [3:0]    wr_nib,
    input  logic          rd_ready,
    output logic          wr_ready,
    output logic          rd_valid,
    output logic          rem_we,
    output logic [AW-1:0] rem_addr,
    output logic [3:0]    rem_wdata,
    output logic          busy,
    output logic          done,
    output logic          err
);
    localparam int LAST = NGRP * ENT_N - 1;

    seq_state_e  state_q;
    logic [3:0]  op_q;
    logic [11:0] pos_q;
    logic [4:0]  left_q;
    logic        done_q;
    logic        err_q;
    logic        run;
    logic        step;

    always_comb begin
        run      = (state_q == S_RUN);
        rd_valid = run && !loc_busy && (op_q == OP_READ);
        wr_ready = run && !loc_busy && (op_q == OP_WRITE);
        rem_we   = run && !loc_busy &&
                   (((op_q == OP_WRITE) && wr_valid) || (op_q == OP_CLEAR));
        case (op_q)
            OP_READ:  step = rd_valid && rd_ready;
            OP_WRITE: step = wr_ready && wr_valid;
            OP_CLEAR: step = run && !loc_busy;
            default:  step = 1'b0;
        endcase
        rem_wdata = (op_q == OP_CLEAR) ? CLEAR_CODE : wr_nib;
        rem_addr  = pos_q[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            pos_q   <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (state_q == S_IDLE) begin
                if (start) begin
                    if (req_ok) begin
                        state_q <= S_RUN;
                        op_q    <= req.op;
                        pos_q   <= {req.grp, req.ent};
                        left_q  <= req.cnt[4:0];
                    end else begin
                        err_q <= 1'b1;
                    end
                end
            end else if (step) begin
                pos_q  <= pos_q + 12'd1;
                left_q <= left_q - 5'd1;
                if (left_q == 5'd1) begin
                    state_q <= S_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign busy = run;
    assign done = done_q;
    assign err  = err_q;

    AST_RUN_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left_q != 5'd0) && (left_q <= 5'(MAX_RUN))); // R7
    AST_ADDR_IN_MEMORY: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(pos_q) <= LAST)); // R8
    AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy && !done); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

endmodule

// File: rtl/gnm_nibble_mem.sv
module gnm_nibble_mem
    import gnm_pkg::*;
#(
    parameter int NGRP = 256,
    localparam int AW    = $clog2(NGRP) + ENT_W,
    localparam int DEPTH = NGRP * ENT_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          loc_en,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [3:0]    loc_wdata,
    output logic [3:0]    loc_rdata,
    input  logic          rem_we,
    input  logic [AW-1:0] rem_addr,
    input  logic [3:0]    rem_wdata,
    output logic [3:0]    rem_rdata
);
    logic [3:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            loc_rdata <= '0;
        end else if (loc_en) begin
            if (loc_we) cells[loc_addr] <= loc_wdata;
            else        loc_rdata       <= cells[loc_addr];
        end else if (rem_we) begin
            cells[rem_addr] <= rem_wdata;
        end
    end

    assign rem_rdata = cells[rem_addr];

    AST_GROUP0_SHIELD: assert property (@(posedge clk) disable iff (rst)
        rem_we |-> (int'(rem_addr) >= ENT_N)); // R6
    AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (rst)
        loc_en |-> !rem_we); // R10

endmodule

// File: rtl/gnm_engine.sv
module gnm_engine
    import gnm_pkg::*;
#(
    parameter int NGRP = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_start,
    input  logic [3:0] req_op,
    input  logic [3:0] req_grp_hi,
    input  logic [3:0] req_grp_lo,
    input  logic [3:0] req_ent,
    input  logic [3:0] req_cnt_hi,
    input  logic [3:0] req_cnt_lo,
    input  logic       wr_valid,
    input  logic [3:0] wr_nib,
    output logic       wr_ready,
    output logic       rd_valid,
    output logic [3:0] rd_nib,
    input  logic       rd_ready,
    input  logic       loc_en,
    input  logic       loc_we,
    input  logic [7:0] loc_grp,
    input  logic [3:0] loc_ent,
    input  logic [3:0] loc_wdata,
    output logic [3:0] loc_rdata,
    output logic       busy,
    output logic       done,
    output logic       err
);
    localparam int AW = $clog2(NGRP) + ENT_W;

    run_req_t      req;
    logic          req_ok;
    logic          rem_we;
    logic [AW-1:0] rem_addr;
    logic [3:0]    rem_wdata;
    logic [AW-1:0] loc_addr;
    logic [11:0]   loc_lin;

    assign req     = '{op: req_op, grp: {req_grp_hi, req_grp_lo},
                       ent: req_ent, cnt: {req_cnt_hi, req_cnt_lo}};
    assign loc_lin  = {loc_grp, loc_ent};
    assign loc_addr = loc_lin[AW-1:0];

    gnm_req_check #(.NGRP(NGRP)) u_check (
        .req (req),
        .ok  (req_ok)
    );

    gnm_seq #(.NGRP(NGRP)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (req_start),
        .req       (req),
        .req_ok    (req_ok),
        .loc_busy  (loc_en),
        .wr_valid  (wr_valid),
        .wr_nib    (wr_nib),
        .rd_ready  (rd_ready),
        .wr_ready  (wr_ready),
        .rd_valid  (rd_valid),
        .rem_we    (rem_we),
        .rem_addr  (rem_addr),
        .rem_wdata (rem_wdata),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    gnm_nibble_mem #(.NGRP(NGRP)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .loc_en    (loc_en),
        .loc_we    (loc_we),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata),
        .rem_we    (rem_we),
        .rem_addr  (rem_addr),
        .rem_wdata (rem_wdata),
        .rem_rdata (rd_nib)
    );

endmodule

// File: tb/sim_gnm_engine.sv
module sim_gnm_engine;

    localparam int NGRP  = 4;
    localparam int DEPTH = NGRP * 16;
    localparam int NVEC  = 15;
    // {op[3:0], grp[7:0], ent[3:0], cnt[7:0], expect_refusal}
    localparam logic [24:0] VEC [NVEC] = '{
        {4'd2, 8'h01, 4'hE, 8'd4,  1'b0},  // R3 write, carry into group 2
        {4'd1, 8'h01, 4'hE, 8'd4,  1'b0},  // R4 read back across groups
        {4'd3, 8'h02, 4'h0, 8'd1,  1'b0},  // R5 single clear
        {4'd2, 8'h00, 4'h3, 8'd2,  1'b1},  // R6 write to group 0
        {4'd3, 8'h00, 4'h0, 8'd1,  1'b1},  // R6 clear of group 0
        {4'd1, 8'h00, 4'h0, 8'd2,  1'b0},  // R6 read of group 0 allowed
        {4'd2, 8'h03, 4'h0, 8'd0,  1'b1},  // R7 zero length
        {4'd2, 8'h03, 4'h0, 8'd17, 1'b1},  // R7 length 17
        {4'd2, 8'h03, 4'h1, 8'd16, 1'b1},  // R8 one past the end
        {4'd2, 8'h03, 4'h0, 8'd16, 1'b0},  // R8 exactly to the end
        {4'd5, 8'h01, 4'h0, 8'd1,  1'b1},  // R9 unknown op
        {4'd0, 8'h01, 4'h0, 8'd1,  1'b1},  // R9 op zero
        {4'd2, 8'h04, 4'h0, 8'd1,  1'b1},  // R8 group beyond memory
        {4'd3, 8'h03, 4'h4, 8'd3,  1'b0},  // R5 clear run
        {4'd1, 8'h03, 4'h0, 8'd16, 1'b0}   // R4 full group read
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_start = 1'b0;
    logic [3:0] req_op = '0, req_grp_hi = '0, req_grp_lo = '0, req_ent = '0;
    logic [3:0] req_cnt_hi = '0, req_cnt_lo = '0;
    logic       wr_valid = 1'b0;
    logic [3:0] wr_nib = '0;
    logic       wr_ready, rd_valid;
    logic [3:0] rd_nib;
    logic       rd_ready = 1'b0;
    logic       loc_en = 1'b0, loc_we = 1'b0;
    logic [7:0] loc_grp = '0;
    logic [3:0] loc_ent = '0, loc_wdata = '0;
    logic [3:0] loc_rdata;
    logic       busy, done, err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] model [DEPTH];
    logic [3:0] wbuf [16];
    logic [3:0] rbuf [16];
    logic       saw_err;

    always #10 clk = ~clk;

    gnm_engine #(.NGRP(NGRP)) u0 (.*);

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic loc_read(input int a, output logic [3:0] d);
        @(negedge clk);
        loc_en = 1'b1; loc_we = 1'b0;
        loc_grp = 8'(a / 16); loc_ent = 4'(a % 16);
        @(negedge clk);
        loc_en = 1'b0;
        d = loc_rdata;
    endtask

    task automatic mem_compare(input string req);
        int bad = 0;
        int first_a = 0;
        logic [3:0] d;
        for (int a = 0; a < DEPTH; a++) begin
            loc_read(a, d);
            if (d !== model[a]) begin
                if (bad == 0) first_a = a;
                bad++;
            end
        end
        check(req, bad == 0, bad, 0);
        if (bad != 0) $display("  first mismatch at entry %0d", first_a);
    endtask

    task automatic run_op(input logic [3:0] op, input logic [7:0] g, input logic [3:0] e,
                          input logic [7:0] c);
        int i = 0;
        int guard = 0;
        @(negedge clk);
        req_op = op; req_grp_hi = g[7:4]; req_grp_lo = g[3:0]; req_ent = e;
        req_cnt_hi = c[7:4]; req_cnt_lo = c[3:0]; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        saw_err = err;
        if (err) return;
        while (!done && guard < 200) begin
            guard++;
            wr_valid = (op == 4'd2) && (i < int'(c));
            wr_nib   = wbuf[i % 16];
            rd_ready = (op == 4'd1);
            #1;
            if (wr_valid && wr_ready) i++;
            if (rd_valid && rd_ready) begin
                rbuf[i % 16] = rd_nib;
                i++;
            end
            @(negedge clk);
        end
        wr_valid = 1'b0; rd_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [3:0] d;
        for (int a = 0; a < DEPTH; a++) model[a] = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 idle outputs", !busy && !done && !err && !wr_ready && !rd_valid,
              {busy, done, err, wr_ready, rd_valid}, 0);
        loc_read(37, d);
        check("R1 reset contents", d == 4'h0, d, 0);

        // R1 local write then read
        @(negedge clk);
        loc_en = 1'b1; loc_we = 1'b1; loc_grp = 8'd0; loc_ent = 4'd5; loc_wdata = 4'hA;
        @(negedge clk);
        loc_en = 1'b0;
        model[5] = 4'hA;
        loc_read(5, d);
        check("R1 local write/read", d == 4'hA, d, 4'hA);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] op; logic [7:0] g; logic [3:0] e; logic [7:0] c; logic x;
            int base;
            {op, g, e, c, x} = VEC[v];
            for (int k = 0; k < 16; k++) wbuf[k] = 4'((k * 3 + v + 1) % 16);
            run_op(op, g, e, c);
            check($sformatf("R2/R6-R9 vector %0d refusal", v), saw_err == x, saw_err, x);
            base = int'(g) * 16 + int'(e);
            if (!x) begin
                if (op == 4'd2)
                    for (int k = 0; k < int'(c); k++) model[base + k] = wbuf[k];
                if (op == 4'd3)
                    for (int k = 0; k < int'(c); k++) model[base + k] = 4'hF;
                if (op == 4'd1) begin
                    int bad = 0;
                    for (int k = 0; k < int'(c); k++)
                        if (rbuf[k] !== model[base + k]) bad++;
                    check($sformatf("R4 vector %0d read data", v), bad == 0, bad, 0);
                end
            end
            mem_compare($sformatf("R3/R5/R9 vector %0d memory", v));
        end

        // R11 timing of a clear run of three
        @(negedge clk);
        req_op = 4'd3; req_grp_hi = 4'd0; req_grp_lo = 4'd1; req_ent = 4'd0;
        req_cnt_hi = 4'd0; req_cnt_lo = 4'd3; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check("R11 busy after accept", busy && !done, {busy, done}, 2'b10);
        @(negedge clk);
        check("R11 busy mid run", busy && !done, {busy, done}, 2'b10);
        @(negedge clk);
        check("R11 busy last step", busy && !done, {busy, done}, 2'b10);
        @(negedge clk);
        check("R11 done pulse", !busy && done, {busy, done}, 2'b01);
        @(negedge clk);
        check("R11 done single", !done, done, 0);
        for (int k = 0; k < 3; k++) model[16 + k] = 4'hF;

        // R10 local priority during a write run
        @(negedge clk);
        req_op = 4'd2; req_grp_hi = 4'd0; req_grp_lo = 4'd2; req_ent = 4'd8;
        req_cnt_hi = 4'd0; req_cnt_lo = 4'd2; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        loc_en = 1'b1; loc_we = 1'b1; loc_grp = 8'd3; loc_ent = 4'd15; loc_wdata = 4'h6;
        wr_valid = 1'b1; wr_nib = 4'h9;
        #1;
        check("R10 no handshake while local active", !wr_ready, wr_ready, 0);
        @(negedge clk);
        loc_en = 1'b0;
        model[63] = 4'h6;
        #1;
        check("R10 handshake resumes", wr_ready, wr_ready, 1);
        @(negedge clk);
        wr_nib = 4'h4;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R10 run completes", done, done, 1);
        model[40] = 4'h9; model[41] = 4'h4;
        mem_compare("R10 memory after shared cycles");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule